// File: doc/BRIEF.md
# Display Memory Host Readback Pipeline

This block is the host read path from the display memory. The data port answers every host read strobe from an output register. Behind that register sits a two-stage prefetch. The first stage is a RAM read in flight, and the second is a one-pixel buffer. When no read is pending, the pipeline fetches the next pixel ahead of the host.

The host reads one step behind. Each strobe returns what the output register holds at that moment. The strobe then moves the next item into the register. After a command moves the read pointer, the host must therefore issue one throw-away read before the pixel at the new address appears on the port. This rule applies on both bus widths.

Pixels are 16 bits wide. On a 16-bit host bus a pixel is one read. On an 8-bit host bus a pixel is two reads: the upper byte comes first, then the lower byte. The read pointer moves on only when the lower byte has been taken.

Top module: `rdp_read_port`

The control is one state machine with three fill states and a byte-phase flag:
- ST_EMPTY: no pixel is held and no fetch is in flight. The machine issues a RAM read and goes to ST_FETCH.
- ST_FETCH: the RAM word arrives.
  - If a load consumes the whole pixel in this cycle, the machine returns to ST_EMPTY.
  - Otherwise it stores the word in the buffer and goes to ST_FULL.
- ST_FULL: a pixel waits in the buffer. A consuming load sends the machine to ST_EMPTY. Any other cycle stays in ST_FULL.
- A move pulse forces ST_EMPTY from any state.

The byte phase moves from PH_HI to PH_LO when an upper byte is loaded, and back to PH_HI when a lower byte is loaded. A move pulse or a 16-bit load sets it to PH_HI.

## Requirements
- R1: While reset is held, `host_data` is 0 and `ram_raddr` is 0. After release, the first strobe is the throw-away read and the second strobe returns the pixel at address 0.
- R2: In the cycle after a `ptr_move` pulse, `ram_re` is 1 and `ram_raddr` equals the `ptr_value` sampled with the pulse.
- R3: After a pointer move, the first strobe is a throw-away read. The next strobe returns the pixel at the new address, on both bus widths.
- R4: With `wide_bus`=1, every strobe after the throw-away read returns a whole pixel on `host_data[15:0]`, at consecutive addresses.
- R5: With `wide_bus`=0, the pixel at each address is returned over two strobes. The first gives bits 15:8 on `host_data[7:0]`, the second gives bits 7:0. Bits 15:8 of `host_data` are 0 in both.
- R6: With `wide_bus`=0, no RAM read is issued while the lower byte of the held pixel is still pending. The next fetch is issued in the cycle after the strobe that loads the lower byte.
- R7: A RAM read lasts one cycle. `ram_re` is never high in two consecutive cycles without a move in between. Each issued read advances `ram_raddr` by one.
- R8: A move discards a fetch in flight and a half-read pixel. It sets the byte phase back to the upper byte.
- R9: A move leaves `host_data` unchanged. A strobe in the same cycle as a move is dropped: it loads nothing and does not count as the throw-away read.
- R10: Strobes spaced at least two cycles apart are each answered. When a pixel waits in the buffer, `host_data` takes its new value at the clock edge that samples the strobe. `host_data` never changes in a cycle with no strobe in that cycle or the one before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | One-cycle host read request |
| wide_bus | input | 1 | 1 = 16-bit host bus, 0 = 8-bit host bus |
| ptr_move | input | 1 | One-cycle pulse: the read pointer was set by command |
| ptr_value | input | 14 | New read pointer, sampled with `ptr_move` |
| ram_rdata | input | 16 | RAM read data, valid one cycle after `ram_re` |
| ram_re | output | 1 | RAM read enable |
| ram_raddr | output | 14 | RAM read address |
| host_data | output | 16 | Output register returned to the host |

## Verification
The RAM read is issued in the cycle right after a move or a consuming load, so the bench checks `ram_re` and `ram_raddr` at the falling edge that follows that clock edge. Data then appears one step late at the port. The bench samples `host_data` in the strobe cycle, before the edge, and compares it with the item loaded by the previous strobe. Where the buffer is already full, the bench also checks that the register changes at the very next edge. Other checks, such as those on a move, confirm that nothing happened over the following cycles.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FETCH = 2'd1,
        ST_FULL  = 2'd2
    } fill_state_e;

    typedef enum logic {
        PH_HI = 1'b0,
        PH_LO = 1'b1
    } byte_phase_e;

    typedef struct packed {
        logic load;      // write output register
        logic from_ram;  // source is RAM data, not buffer
        logic hi_byte;   // narrow bus: pick upper half
        logic wide;      // 16-bit bus: whole pixel
        logic capture;   // store RAM data into buffer
    } load_ctl_t;

endpackage

// File: rtl/rdp_addr_ctr.sv
module rdp_addr_ctr #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            addr <= addr + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/rdp_fsm.sv
module rdp_fsm
    import rdp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ptr_move,
    input  logic        rd_strobe,
    input  logic        wide_bus,
    output logic        fetch,
    output load_ctl_t   ctl,
    output fill_state_e state,
    output byte_phase_e phase
);

    fill_state_e state_n;
    byte_phase_e phase_n;
    logic        pend_q, pend_n;
    logic        take, consume;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_EMPTY;
            phase  <= PH_HI;
            pend_q <= 1'b0;
        end else begin
            state  <= state_n;
            phase  <= phase_n;
            pend_q <= pend_n;
        end
    end

    // load decision
    always_comb begin
        take = 1'b0;
        unique case (state)
            ST_EMPTY: take = 1'b0;
            ST_FETCH: take = rd_strobe || pend_q;
            ST_FULL:  take = rd_strobe;
            default:  take = 1'b0;
        endcase
        if (ptr_move) take = 1'b0;
        consume = take && (wide_bus || (phase == PH_LO));
    end

    // next state
    always_comb begin
        state_n = state;
        phase_n = phase;
        pend_n  = 1'b0;
        if (ptr_move) begin
            state_n = ST_EMPTY;
            phase_n = PH_HI;
        end else begin
            unique case (state)
                ST_EMPTY: begin
                    state_n = ST_FETCH;
                    pend_n  = rd_strobe;
                end
                ST_FETCH: state_n = consume ? ST_EMPTY : ST_FULL;
                ST_FULL:  state_n = consume ? ST_EMPTY : ST_FULL;
                default:  state_n = ST_EMPTY;
            endcase
            if (take) begin
                phase_n = (wide_bus || phase == PH_LO) ? PH_HI : PH_LO;
            end
        end
    end

    // outputs
    always_comb begin
        fetch        = (state == ST_EMPTY);
        ctl.load     = take;
        ctl.from_ram = (state == ST_FETCH);
        ctl.hi_byte  = (phase == PH_HI);
        ctl.wide     = wide_bus;
        ctl.capture  = (state == ST_FETCH) && !consume && !ptr_move;
    end

endmodule

// File: rtl/rdp_out_stage.sv
module rdp_out_stage
    import rdp_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  load_ctl_t        ctl,
    input  logic [PIX_W-1:0] ram_rdata,
    output logic [PIX_W-1:0] host_data
);

    localparam int HALF = PIX_W / 2;

    logic [PIX_W-1:0] buf_q;
    logic [PIX_W-1:0] src;
    logic [HALF-1:0]  part;
    logic [PIX_W-1:0] shaped;

    always_comb begin
        src    = ctl.from_ram ? ram_rdata : buf_q;
        part   = ctl.hi_byte ? src[PIX_W-1:HALF] : src[HALF-1:0];
        shaped = ctl.wide ? src : {{(PIX_W-HALF){1'b0}}, part};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q     <= '0;
            host_data <= '0;
        end else begin
            if (ctl.capture) buf_q <= ram_rdata;
            if (ctl.load)    host_data <= shaped;
        end
    end

endmodule

// File: rtl/rdp_read_port.sv
module rdp_read_port
    import rdp_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int PIX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              wide_bus,
    input  logic              ptr_move,
    input  logic [ADDR_W-1:0] ptr_value,
    input  logic [PIX_W-1:0]  ram_rdata,
    output logic              ram_re,
    output logic [ADDR_W-1:0] ram_raddr,
    output logic [PIX_W-1:0]  host_data
);

    load_ctl_t   ctl;
    fill_state_e fill_state;
    byte_phase_e byte_phase;
    logic        fetch;

    rdp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_move  (ptr_move),
        .rd_strobe (rd_strobe),
        .wide_bus  (wide_bus),
        .fetch     (fetch),
        .ctl       (ctl),
        .state     (fill_state),
        .phase     (byte_phase)
    );

    rdp_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_move),
        .load_val (ptr_value),
        .step     (fetch),
        .addr     (ram_raddr)
    );

    rdp_out_stage #(.PIX_W(PIX_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .ram_rdata (ram_rdata),
        .host_data (host_data)
    );

    assign ram_re = fetch;

endmodule

// File: rtl/rdp_read_port_chk.sv
module rdp_read_port_chk
    import rdp_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int PIX_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe,
    input logic              ptr_move,
    input logic [ADDR_W-1:0] ptr_value,
    input logic              ram_re,
    input logic [ADDR_W-1:0] ram_raddr,
    input logic [PIX_W-1:0]  host_data,
    input fill_state_e       fill_state,
    input byte_phase_e       byte_phase
);

    assert_fetch_after_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_move |=> (ram_re && ram_raddr == $past(ptr_value)));

    assert_single_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_re && !ptr_move) |=> !ram_re);

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_re && !ptr_move) |=> ram_raddr == ADDR_W'($past(ram_raddr) + ADDR_W'(1)));

    assert_low_byte_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_phase == PH_LO) |-> (!ram_re && fill_state == ST_FULL));

    assert_move_keeps_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_move |=> $stable(host_data));

    assert_quiet_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe && !$past(rd_strobe)) |=> $stable(host_data));

endmodule

bind rdp_read_port rdp_read_port_chk #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_strobe  (rd_strobe),
    .ptr_move   (ptr_move),
    .ptr_value  (ptr_value),
    .ram_re     (ram_re),
    .ram_raddr  (ram_raddr),
    .host_data  (host_data),
    .fill_state (fill_state),
    .byte_phase (byte_phase)
);

// File: tb/sim_rdp_read_port.sv
`timescale 1ns/1ps
module sim_rdp_read_port;

    localparam int AW = 14;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_strobe = 1'b0;
    logic          wide_bus = 1'b1;
    logic          ptr_move = 1'b0;
    logic [AW-1:0] ptr_value = '0;
    logic [PW-1:0] ram_rdata = '0;
    logic          ram_re;
    logic [AW-1:0] ram_raddr;
    logic [PW-1:0] host_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    rdp_read_port #(.ADDR_W(AW), .PIX_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .wide_bus(wide_bus),
        .ptr_move(ptr_move), .ptr_value(ptr_value), .ram_rdata(ram_rdata),
        .ram_re(ram_re), .ram_raddr(ram_raddr), .host_data(host_data)
    );

    function automatic logic [PW-1:0] pix(input logic [AW-1:0] a);
        return {2'b10, a} ^ {a[6:0], a[13:5]};
    endfunction

    function automatic logic [PW-1:0] hi_of(input logic [AW-1:0] a);
        logic [PW-1:0] p = pix(a);
        return {8'h00, p[15:8]};
    endfunction

    function automatic logic [PW-1:0] lo_of(input logic [AW-1:0] a);
        logic [PW-1:0] p = pix(a);
        return {8'h00, p[7:0]};
    endfunction

    // RAM model, one cycle read latency
    always @(posedge clk) begin
        if (ram_re) ram_rdata <= pix(ram_raddr);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [PW-1:0] v);
        @(negedge clk);
        rd_strobe = 1'b1;
        v = host_data;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic set_ptr(input logic [AW-1:0] a, input logic with_strobe);
        @(negedge clk);
        ptr_move  = 1'b1;
        ptr_value = a;
        rd_strobe = with_strobe;
        @(negedge clk);
        ptr_move  = 1'b0;
        rd_strobe = 1'b0;
    endtask

    task automatic t_reset();
        logic [PW-1:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset data", 32'(host_data), 32'h0);
        chk("R1 reset addr", 32'(ram_raddr), 32'h0);
        rst_n = 1'b1;
        do_read(v);   // throw-away
        do_read(v);
        chk("R1 first pixel", 32'(v), 32'(pix(0)));
    endtask

    task automatic t_wide_stream();
        logic [PW-1:0] v;
        wide_bus = 1'b1;
        set_ptr(14'd100, 1'b0);
        chk("R2 fetch issued", 32'(ram_re), 32'h1);
        chk("R2 fetch addr", 32'(ram_raddr), 32'd100);
        do_read(v);   // throw-away
        for (int i = 0; i < 5; i++) begin
            do_read(v);
            chk(i == 0 ? "R3 wide first pixel" : "R4 wide stream", 32'(v), 32'(pix(AW'(100 + i))));
        end
        repeat (3) @(negedge clk);
        chk("R7 addr after stream", 32'(ram_raddr), 32'd107);
        chk("R7 ram idle", 32'(ram_re), 32'h0);
    endtask

    task automatic t_narrow_stream();
        logic [PW-1:0] v;
        wide_bus = 1'b0;
        set_ptr(14'd200, 1'b0);
        chk("R2 narrow fetch", 32'(ram_raddr), 32'd200);
        repeat (2) @(negedge clk);
        chk("R7 one fetch", 32'(ram_raddr), 32'd201);
        do_read(v);   // throw-away, loads upper byte
        for (int i = 0; i < 3; i++) begin
            chk("R6 no fetch before low byte", 32'(ram_re), 32'h0);
            chk("R6 addr held", 32'(ram_raddr), 32'd201);
            @(negedge clk);
        end
        do_read(v);
        chk("R3 narrow first byte", 32'(v), 32'(hi_of(200)));
        chk("R6 fetch after low load", 32'(ram_re), 32'h1);
        chk("R6 fetch addr", 32'(ram_raddr), 32'd201);
        do_read(v);
        chk("R5 low byte", 32'(v), 32'(lo_of(200)));
        do_read(v);
        chk("R5 next high", 32'(v), 32'(hi_of(201)));
        do_read(v);
        chk("R5 next low", 32'(v), 32'(lo_of(201)));
    endtask

    task automatic t_flush();
        logic [PW-1:0] v;
        wide_bus = 1'b0;
        set_ptr(14'd300, 1'b0);
        do_read(v);   // throw-away, half pixel now pending
        set_ptr(14'd400, 1'b0);
        do_read(v);   // throw-away
        do_read(v);
        chk("R8 phase reset high", 32'(v), 32'(hi_of(400)));
        do_read(v);
        chk("R8 low after flush", 32'(v), 32'(lo_of(400)));
        do_read(v);
        chk("R8 next high", 32'(v), 32'(hi_of(401)));
        wide_bus = 1'b1;
        set_ptr(14'd500, 1'b0);
        @(negedge clk);
        ptr_move = 1'b1; ptr_value = 14'd600;   // fetch of 500 in flight
        @(negedge clk);
        ptr_move = 1'b0;
        do_read(v);   // throw-away
        do_read(v);
        chk("R8 in-flight dropped", 32'(v), 32'(pix(600)));
    endtask

    task automatic t_collide();
        logic [PW-1:0] v, h;
        wide_bus = 1'b1;
        set_ptr(14'd700, 1'b0);
        do_read(v);
        do_read(v);
        chk("R4 pixel 700", 32'(v), 32'(pix(700)));
        h = host_data;
        set_ptr(14'd800, 1'b1);
        chk("R9 output kept", 32'(host_data), 32'(h));
        repeat (2) @(negedge clk);
        chk("R9 output still kept", 32'(host_data), 32'(h));
        do_read(v);   // throw-away
        do_read(v);
        chk("R9 strobe with move dropped", 32'(v), 32'(pix(800)));
    endtask

    task automatic t_slow();
        wide_bus = 1'b1;
        set_ptr(14'd900, 1'b0);
        repeat (4) @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        chk("R10 load at strobe edge", 32'(host_data), 32'(pix(900)));
        repeat (4) @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        chk("R10 next load", 32'(host_data), 32'(pix(901)));
    endtask

    initial begin
        t_reset();
        t_wide_stream();
        t_narrow_stream();
        t_flush();
        t_collide();
        t_slow();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule